// File: doc/BRIEF.md
# Keyed Column Mixer for the AES Round

This block takes one 32-bit column of the AES state and returns that column mixed and keyed in a single pass. The mixing treats the column as a polynomial whose four coefficients are bytes. It multiplies that polynomial by the fixed round polynomial, reduced modulo x^4 + 1. The 32-bit round-key word for the same column is XORed in by the same XOR tree. There is no separate key-addition stage after the mix.

The datapath has two register stages. The first stage holds two things for each output byte. One is an 8-bit linear sum: the shifted bytes, the plain bytes and the key byte. The other is a single reduction bit, the XOR of the two most significant bits that the doubling terms would fold back. The second stage adds the reduction constant 0x1B when that bit is set. A new column may enter on every clock. A valid strobe travels beside the data. The output data holds its last value whenever no valid column is moving through.

Top module: `colmix_key_top`

## Requirements
- R1: Byte j of a 32-bit word sits at bits [31-8j : 24-8j], so byte 0 is the most significant byte. For input column bytes a0..a3 and key bytes k0..k3, output byte i equals 02·a(i) ^ 03·a(i+1) ^ a(i+2) ^ a(i+3) ^ k(i), with indices taken mod 4. For example, the column db135345 with key 0 gives 8e4da1bc.
- R2: Multiplying by 02 in GF(2^8) is a left shift by one bit. When the byte's bit 7 was 1, the result is also XORed with 0x1B. Multiplying by 03 equals 02·a ^ a. A column with only its most significant byte at 0x80 and a zero key gives 1b80809b.
- R3: An all-zero column produces exactly the key word at the output.
- R4: A column whose four bytes are equal produces that column XOR the key.
- R5: A column sampled with in_vld high at a rising edge appears on out_col, with out_vld high, after the next rising edge. out_vld is in_vld delayed by two register stages.
- R6: Columns presented on consecutive cycles each produce their own result on consecutive cycles.
- R7: While in_vld is low, in_col and in_key have no effect. Two edges later out_vld is low, and out_col keeps the last valid result.
- R8: While rst is high at a rising edge, both stages are cleared. After that edge out_vld is 0 and out_col is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Marks in_col and in_key as a column to process |
| in_col | input | 32 | State column, byte 0 in the top bits |
| in_key | input | 32 | Round-key word for this column |
| out_vld | output | 1 | Marks out_col as a fresh result |
| out_col | output | 32 | Mixed and keyed column |

## Verification
The assertions assume that the inputs are defined at every edge after reset, and that the data inputs matter only in a cycle where in_vld is high. The zero-column and equal-byte properties also assume that the inputs arrive in step with in_vld. The stimulus drives every input at the falling edge, so each value is stable at the next rising edge. It puts random data on the data inputs while in_vld is low, which exercises the hold rule. The directed columns cover the published example, a column that forces the reduction, a zero column and a column of equal bytes. They are mixed with a seeded random stream that has gaps.

// File: rtl/mixkey_pkg.sv
package mixkey_pkg;

    localparam int BYTE_W    = 8;
    localparam int COL_BYTES = 4;
    localparam int COL_W     = BYTE_W * COL_BYTES;
    localparam int PIPE_LVLS = 2;

    localparam logic [BYTE_W-1:0] REDUCE_POLY = 8'h1B;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [COL_W-1:0]  col_t;

    // First-stage record for one output byte: linear part plus folded MSB term
    typedef struct packed {
        byte_t lin;
        logic  red;
    } lane_s1_t;

    function automatic byte_t shl1(input byte_t b);
        return {b[BYTE_W-2:0], 1'b0};
    endfunction

    function automatic byte_t fold_red(input byte_t lin, input logic red);
        return lin ^ (red ? REDUCE_POLY : '0);
    endfunction

    function automatic byte_t col_byte(input col_t c, input int j);
        return c[COL_W-1-BYTE_W*j -: BYTE_W];
    endfunction

endpackage

// File: rtl/mixkey_vld_pipe.sv
module mixkey_vld_pipe
    import mixkey_pkg::*;
#(
    parameter int DEPTH = PIPE_LVLS
) (
    input  logic clk,
    input  logic rst,
    input  logic vld_in,
    output logic vld_s1,
    output logic vld_out
);
    logic [DEPTH-1:0] sr;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    sr[g] <= 1'b0;
                else if (g == 0)
                    sr[g] <= vld_in;
                else
                    sr[g] <= sr[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign vld_s1  = sr[0];
    assign vld_out = sr[DEPTH-1];
endmodule

// File: rtl/mixkey_lane.sv
module mixkey_lane
    import mixkey_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld1,
    input  logic  ld2,
    input  byte_t a_dbl,   // coefficient 02
    input  byte_t a_tri,   // coefficient 03
    input  byte_t a_p1,    // coefficient 01
    input  byte_t a_p2,    // coefficient 01
    input  byte_t k,
    output byte_t y
);
    lane_s1_t s1_d, s1_q;

    // Shifted halves of 02·a_dbl and 02·a_tri are linear; only their MSBs feed the reduction bit
    always_comb begin
        s1_d.lin = shl1(a_dbl) ^ shl1(a_tri) ^ a_tri ^ a_p1 ^ a_p2 ^ k;
        s1_d.red = a_dbl[BYTE_W-1] ^ a_tri[BYTE_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst)
            s1_q <= '0;
        else if (ld1)
            s1_q <= s1_d;
    end

    always_ff @(posedge clk) begin
        if (rst)
            y <= '0;
        else if (ld2)
            y <= fold_red(s1_q.lin, s1_q.red);
    end

    // R7: output byte holds when the first stage carries no column
    a_r7_lane_hold: assert property (@(posedge clk) disable iff (rst)
        !ld2 |=> $stable(y));
endmodule

// File: rtl/colmix_key_top.sv
module colmix_key_top
    import mixkey_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_vld,
    input  logic [31:0] in_col,
    input  logic [31:0] in_key,
    output logic        out_vld,
    output logic [31:0] out_col
);
    logic vld_s1;

    mixkey_vld_pipe #(.DEPTH(PIPE_LVLS)) u_vld (
        .clk    (clk),
        .rst    (rst),
        .vld_in (in_vld),
        .vld_s1 (vld_s1),
        .vld_out(out_vld)
    );

    genvar i;
    generate
        for (i = 0; i < COL_BYTES; i++) begin : g_lane
            byte_t y;
            mixkey_lane u_lane (
                .clk  (clk),
                .rst  (rst),
                .ld1  (in_vld),
                .ld2  (vld_s1),
                .a_dbl(col_byte(in_col, i)),
                .a_tri(col_byte(in_col, (i+1) % COL_BYTES)),
                .a_p1 (col_byte(in_col, (i+2) % COL_BYTES)),
                .a_p2 (col_byte(in_col, (i+3) % COL_BYTES)),
                .k    (col_byte(in_key, i)),
                .y    (y)
            );
            assign out_col[COL_W-1-BYTE_W*i -: BYTE_W] = y;
        end
    endgenerate

    // Edges since reset, saturating, so two-deep history is never pre-reset
    logic [1:0] warm_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            warm_cnt <= '0;
        else if (warm_cnt != 2'd2)
            warm_cnt <= warm_cnt + 2'd1;
    end
    wire warm = (warm_cnt == 2'd2);

    // R5: valid travels exactly two stages
    a_r5_vld_latency: assert property (@(posedge clk) disable iff (rst)
        warm |-> (out_vld == $past(in_vld, 2)));

    // R3: zero column yields the key word
    a_r3_zero_col: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(in_vld, 2) && ($past(in_col, 2) == '0))
        |-> (out_col == $past(in_key, 2)));

    // R4: equal bytes are a fixed point of the mix
    a_r4_equal_bytes: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(in_vld, 2) &&
         ($past(in_col, 2) == {4{$past(in_col[7:0], 2)}}))
        |-> (out_col == ($past(in_col, 2) ^ $past(in_key, 2))));

    // R6: a valid column two edges back always produces a valid result
    a_r6_stream: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(in_vld, 2) && $past(in_vld, 1)) |-> out_vld);
endmodule

// File: tb/colmix_key_top_tb_top.sv
`timescale 1ns/1ps
module colmix_key_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [31:0] in_col = '0;
    logic [31:0] in_key = '0;
    logic        out_vld;
    logic [31:0] out_col;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    colmix_key_top dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_col(in_col),
        .in_key(in_key), .out_vld(out_vld), .out_col(out_col)
    );

    function automatic logic [7:0] gmul2(input logic [7:0] b);
        logic [7:0] r;
        r = b << 1;
        if (b[7]) r = r ^ 8'h1B;
        return r;
    endfunction

    function automatic logic [31:0] ref_mix(input logic [31:0] c, input logic [31:0] k);
        logic [7:0] a [4];
        logic [7:0] o [4];
        for (int j = 0; j < 4; j++) a[j] = c[31-8*j -: 8];
        for (int j = 0; j < 4; j++)
            o[j] = gmul2(a[j]) ^ gmul2(a[(j+1)%4]) ^ a[(j+1)%4]
                 ^ a[(j+2)%4] ^ a[(j+3)%4] ^ k[31-8*j -: 8];
        return {o[0], o[1], o[2], o[3]};
    endfunction

    // model history: entries driven one and two steps ago
    logic        h1_v = 0, h2_v = 0;
    logic [31:0] h1_c = 0, h2_c = 0, h1_k = 0, h2_k = 0;
    string       h1_t = "R8", h2_t = "R8";
    logic [31:0] exp_data = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] c, input logic [31:0] k, input string tag);
        @(negedge clk);
        if (h2_v) exp_data = ref_mix(h2_c, h2_k);
        check({h2_t, "/R5 valid"}, {31'd0, out_vld}, {31'd0, h2_v});
        check(h2_v ? h2_t : "R7", out_col, exp_data);
        h2_v = h1_v; h2_c = h1_c; h2_k = h1_k; h2_t = h1_t;
        h1_v = v;    h1_c = c;    h1_k = k;    h1_t = tag;
        in_vld = v; in_col = c; in_key = k;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 valid", {31'd0, out_vld}, 32'd0);
        check("R8 data", out_col, 32'd0);
        rst = 1'b0;
        h1_v = 0; h2_v = 0; exp_data = '0;
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h1357_2468);
        do_reset();
        step(1, 32'hdb135345, 32'h0, "R1");
        step(1, 32'h80000000, 32'h0, "R2");
        step(1, 32'h0, 32'hdeadbeef, "R3");
        step(1, 32'h5a5a5a5a, 32'h01234567, "R4");
        step(1, 32'hffffffff, 32'h0, "R4");
        step(0, 32'hcafef00d, 32'h12345678, "R7");
        step(0, 32'h11111111, 32'h22222222, "R7");
        step(1, 32'h80808080, 32'h0, "R2");
        step(1, 32'h00800080, 32'h0, "R2");
        for (int i = 0; i < 200; i++)
            step(1, $urandom(), $urandom(), "R6");
        for (int i = 0; i < 300; i++)
            step(($urandom() % 3) != 0, $urandom(), $urandom(), "R1");
        step(1, $urandom(), $urandom(), "R1");
        do_reset();
        step(1, 32'hf20a225c, 32'h0, "R1");
        for (int i = 0; i < 4; i++)
            step(0, $urandom(), $urandom(), "R7");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule